// File: doc/BRIEF.md
# Power-Up Strap Capture and Frequency Index Sequencer

This block handles a handful of clock-generator pins that do double duty. While the supply is ramping, the pins act as inputs, and their levels set the configuration. Those levels are captured once, when the supply-good indication is first seen. The pins then turn into outputs held low while a power-up timer runs from the reference oscillator. When the timer ends, the block allows every clock output to toggle. The captured values are the three frequency-select straps, the pin-role mode strap, the SDRAM source strap and the CPU supply strap. Each of them reads 1 when nothing drives the pin, and the capture registers reset to all ones to match.

After the timer expires, the block works out which frequency-table index is in force. It takes the index from the hardware straps or from a software control byte. The index goes to the PLL programming logic over a valid/ready channel. A new index is offered only when the selected value differs from the one last accepted. While `idx_valid_o` is high, `idx_o` holds steady until `idx_ready_i` is seen high at a clock edge, and no later value overtakes a pending one. With `idx_ready_i` tied high, every change shows up as a one-cycle strobe.

Top module: `strap_freq_seq`

## Requirements
- R1: While reset is held and until supply-good is first sampled high, the strap pads are inputs (`strap_pad_oe_o` = 0), `clk_run_o` = 0 and `idx_valid_o` = 0.
- R2: The strap pads are captured at the first clock edge that sees `pwr_good_i` high. After that, changes on the pads or on `pwr_good_i` do not alter the captured values until the next reset.
- R3: From the cycle after capture, `strap_pad_oe_o` = 1 and `clk_run_o` = 0 for exactly `TIMER_CYCLES` cycles. Then `clk_run_o` rises and stays high, and the pads stay outputs.
- R4: The pad bit positions are 0 = FS0, 1 = FS1, 2 = FS2, 3 = pin-role mode, 4 = SDRAM source and 5 = CPU supply. `mode_o` is the captured bit 3. `sdram_follow_cpu_o` is the captured bit 4 (1 = SDRAM follows the CPU, 0 = SDRAM follows AGP). `cpu_vdd_2v5_o` is the captured bit 5 (1 = 2.5 V, 0 = 3.3 V).
- R5: With control byte bit 3 = 0, the selected index is {0, FS2, FS1, FS0} taken from the captured straps.
- R6: With control byte bit 3 = 1, the selected index is {bit 2, bits 6:4} of the control byte when `EXTENDED` = 1. It is {0, bits 6:4} when `EXTENDED` = 0.
- R7: `idx_valid_o` is never high before `clk_run_o` is high.
- R8: The first index is offered on the cycle after `clk_run_o` rises. After that, each new selected value that differs from the last accepted one is offered exactly once.
- R9: While `idx_valid_o` = 1 and `idx_ready_i` = 0, `idx_valid_o` stays high and `idx_o` stays unchanged.
- R10: Control byte bits 7, 1 and 0 never cause an index offer, and neither does bit 2 when it is not part of the selected index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference oscillator clock |
| rst_n_i | input | 1 | Asynchronous active-low true power-on reset |
| pwr_good_i | input | 1 | Supply-good indication |
| strap_pad_i | input | 6 | Levels seen on the strap pads in input mode |
| ctl_reg0_i | input | 8 | Software frequency control byte |
| strap_pad_oe_o | output | 1 | 1 = strap pads are outputs (driven low until run) |
| clk_run_o | output | 1 | 1 = all clock outputs may toggle |
| mode_o | output | 1 | Captured pin-role mode strap |
| sdram_follow_cpu_o | output | 1 | Captured SDRAM source strap |
| cpu_vdd_2v5_o | output | 1 | Captured CPU supply strap |
| idx_valid_o | output | 1 | Frequency index offered |
| idx_ready_i | input | 1 | PLL side accepts the index |
| idx_o | output | 4 | Frequency-table index |

## Verification
The bench shortens `TIMER_CYCLES` to 37, so the whole held-low window can be stepped through and both of its edges checked over several power-up episodes. It builds two copies side by side: one with `EXTENDED` = 1 and one with `EXTENDED` = 0. The same software bytes then show the fourth index bit both honoured and masked. Random strap patterns and control bytes are mixed with directed all-ones and all-zeros straps, a stalled ready, and writes that touch only the ignored bits.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;
  localparam int NUM_STRAPS = 6;
  localparam int IDX_W      = 4;
  localparam int CTL_W      = 8;

  localparam int SP_FS0  = 0;
  localparam int SP_FS1  = 1;
  localparam int SP_FS2  = 2;
  localparam int SP_MODE = 3;
  localparam int SP_SDS  = 4;
  localparam int SP_VDD  = 5;

  localparam int CB_SRC_SW = 3;
  localparam int CB_MSB    = 2;
  localparam int CB_SEL_LO = 4;

  typedef enum logic [1:0] {
    PH_SENSE = 2'd0,
    PH_HOLD  = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;
endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_i,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] val_o
);
  // Reset to all ones: an undriven strap reads high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     val_o <= '1;
    else if (cap_i) val_o <= pad_i;
  end
endmodule

// File: rtl/pwrup_phase.sv
module pwrup_phase
  import strap_seq_pkg::*;
#(
  parameter int TIMER_CYCLES = 42954
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good_i,
  output logic cap_o,
  output logic oe_o,
  output logic run_o
);
  localparam int CNT_W = (TIMER_CYCLES > 2) ? $clog2(TIMER_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMER_CYCLES - 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;

  assign cap_o = (ph_q == PH_SENSE) && pwr_good_i;
  assign oe_o  = (ph_q != PH_SENSE);
  assign run_o = (ph_q == PH_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_SENSE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_SENSE: begin
          cnt_q <= '0;
          if (pwr_good_i) ph_q <= PH_HOLD;
        end
        PH_HOLD: begin
          if (cnt_q == LAST) ph_q <= PH_RUN;
          else               cnt_q <= cnt_q + 1'b1;
        end
        default: ph_q <= PH_RUN;
      endcase
    end
  end
endmodule

// File: rtl/freq_index_sel.sv
module freq_index_sel
  import strap_seq_pkg::*;
#(
  parameter bit EXTENDED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [2:0]       fs_i,
  input  logic [CTL_W-1:0] ctl_i,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [IDX_W-1:0] idx_o
);
  logic             sw_msb;
  logic [IDX_W-1:0] sel;
  logic [IDX_W-1:0] sent_q;
  logic             sent_ok_q;

  generate
    if (EXTENDED) begin : g_ext
      assign sw_msb = ctl_i[CB_MSB];
    end else begin : g_base
      assign sw_msb = 1'b0;
    end
  endgenerate

  assign sel = ctl_i[CB_SRC_SW] ? {sw_msb, ctl_i[CB_SEL_LO +: 3]} : {1'b0, fs_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      idx_o     <= '0;
      sent_q    <= '0;
      sent_ok_q <= 1'b0;
    end else if (valid_o) begin
      if (ready_i) begin
        valid_o   <= 1'b0;
        sent_q    <= idx_o;
        sent_ok_q <= 1'b1;
      end
    end else if (run_i && (!sent_ok_q || sel != sent_q)) begin
      valid_o <= 1'b1;
      idx_o   <= sel;
    end
  end
endmodule

// File: rtl/strap_freq_seq.sv
module strap_freq_seq
  import strap_seq_pkg::*;
#(
  parameter int TIMER_CYCLES = 42954,
  parameter bit EXTENDED     = 1'b1
) (
  input  logic                  clk_ref_i,
  input  logic                  rst_n_i,
  input  logic                  pwr_good_i,
  input  logic [NUM_STRAPS-1:0] strap_pad_i,
  input  logic [CTL_W-1:0]      ctl_reg0_i,
  output logic                  strap_pad_oe_o,
  output logic                  clk_run_o,
  output logic                  mode_o,
  output logic                  sdram_follow_cpu_o,
  output logic                  cpu_vdd_2v5_o,
  output logic                  idx_valid_o,
  input  logic                  idx_ready_i,
  output logic [IDX_W-1:0]      idx_o
);
  logic                  cap;
  logic [NUM_STRAPS-1:0] straps;

  pwrup_phase #(.TIMER_CYCLES(TIMER_CYCLES)) u_phase (
    .clk        (clk_ref_i),
    .rst_n      (rst_n_i),
    .pwr_good_i (pwr_good_i),
    .cap_o      (cap),
    .oe_o       (strap_pad_oe_o),
    .run_o      (clk_run_o)
  );

  strap_capture #(.W(NUM_STRAPS)) u_cap (
    .clk   (clk_ref_i),
    .rst_n (rst_n_i),
    .cap_i (cap),
    .pad_i (strap_pad_i),
    .val_o (straps)
  );

  assign mode_o             = straps[SP_MODE];
  assign sdram_follow_cpu_o = straps[SP_SDS];
  assign cpu_vdd_2v5_o      = straps[SP_VDD];

  freq_index_sel #(.EXTENDED(EXTENDED)) u_sel (
    .clk     (clk_ref_i),
    .rst_n   (rst_n_i),
    .run_i   (clk_run_o),
    .fs_i    ({straps[SP_FS2], straps[SP_FS1], straps[SP_FS0]}),
    .ctl_i   (ctl_reg0_i),
    .valid_o (idx_valid_o),
    .ready_i (idx_ready_i),
    .idx_o   (idx_o)
  );
endmodule

// File: rtl/strap_freq_seq_chk.sv
module strap_freq_seq_chk #(
  parameter bit EXTENDED = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       oe,
  input logic       run,
  input logic       mode,
  input logic       sds,
  input logic       vdd,
  input logic       valid,
  input logic       ready,
  input logic [3:0] idx
);
  a_r1_quiet_in_sense: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!run && !valid));

  a_r2_straps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    oe |=> (oe && $stable({mode, sds, vdd})));

  a_r3_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> run);

  a_r3_run_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> oe);

  a_r7_no_early_offer: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> run);

  a_r9_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(idx)));

  generate
    if (!EXTENDED) begin : g_base
      a_r6_msb_masked: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !idx[3]);
    end
  endgenerate
endmodule

bind strap_freq_seq strap_freq_seq_chk #(.EXTENDED(EXTENDED)) u_chk (
  .clk   (clk_ref_i),
  .rst_n (rst_n_i),
  .oe    (strap_pad_oe_o),
  .run   (clk_run_o),
  .mode  (mode_o),
  .sds   (sdram_follow_cpu_o),
  .vdd   (cpu_vdd_2v5_o),
  .valid (idx_valid_o),
  .ready (idx_ready_i),
  .idx   (idx_o)
);

// File: tb/strap_freq_seq_tb.sv
module strap_freq_seq_tb;
  localparam int T = 37;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pg = 1'b0;
  logic [5:0] pads = 6'h3f;
  logic [7:0] ctl = 8'h00;
  logic       rdy = 1'b1;

  logic       oe, run, mode, sds, vdd, vld, oe_b, run_b, mode_b, sds_b, vdd_b, vld_b;
  logic [3:0] idx, idx_b;

  int checks = 0;
  int fails  = 0;
  logic [3:0] last_a, last_b;
  int offers;

  always #4 clk = ~clk;

  strap_freq_seq #(.TIMER_CYCLES(T), .EXTENDED(1'b1)) u_dut (
    .clk_ref_i(clk), .rst_n_i(rst_n), .pwr_good_i(pg), .strap_pad_i(pads),
    .ctl_reg0_i(ctl), .strap_pad_oe_o(oe), .clk_run_o(run), .mode_o(mode),
    .sdram_follow_cpu_o(sds), .cpu_vdd_2v5_o(vdd), .idx_valid_o(vld),
    .idx_ready_i(rdy), .idx_o(idx));

  strap_freq_seq #(.TIMER_CYCLES(T), .EXTENDED(1'b0)) u_dut_base (
    .clk_ref_i(clk), .rst_n_i(rst_n), .pwr_good_i(pg), .strap_pad_i(pads),
    .ctl_reg0_i(ctl), .strap_pad_oe_o(oe_b), .clk_run_o(run_b), .mode_o(mode_b),
    .sdram_follow_cpu_o(sds_b), .cpu_vdd_2v5_o(vdd_b), .idx_valid_o(vld_b),
    .idx_ready_i(1'b1), .idx_o(idx_b));

  always @(posedge clk) begin
    if (vld && rdy) last_a <= idx;
    if (vld_b)      last_b <= idx_b;
    if (vld)        offers <= offers + 1;
  end

  function automatic logic [3:0] exp_idx(bit ext, logic [5:0] s, logic [7:0] c);
    if (c[3]) return {ext ? c[2] : 1'b0, c[6:4]};
    return {1'b0, s[2:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic episode(logic [5:0] s, int dly);
    @(negedge clk);
    rst_n = 1'b0; pg = 1'b0; pads = s; ctl = 8'h00; rdy = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", oe, 0);
    rst_n = 1'b1;
    repeat (dly) @(negedge clk);
    chk("R1 quiet before pg", {oe, run, vld, oe_b}, 0);
    chk("R4 default straps", {vdd, sds, mode}, 3'b111);
    pg = 1'b1;
    @(negedge clk);
    chk("R3 oe after capture", {oe, run}, 2'b10);
    chk("R4 captured straps", {vdd, sds, mode}, {s[5], s[4], s[3]});
    pads = ~s; pg = 1'b0;
    repeat (T - 1) @(negedge clk);
    chk("R3 still held low", {run, vld}, 0);
    chk("R7 no offer before run", vld_b, 0);
    @(negedge clk);
    chk("R3 run rises", {oe, run, vld}, 3'b110);
    @(negedge clk);
    chk("R8 first offer", {vld, idx}, {1'b1, exp_idx(1'b1, s, 8'h00)});
    chk("R5 hw index base", {vld_b, idx_b}, {1'b1, exp_idx(1'b0, s, 8'h00)});
    repeat (4) @(negedge clk);
    chk("R2 straps frozen", {vdd, sds, mode, run}, {s[5], s[4], s[3], 1'b1});
  endtask

  task automatic set_ctl(logic [5:0] s, logic [7:0] c);
    ctl = c;
    repeat (4) @(negedge clk);
    chk("R5/R6 index ext", last_a, exp_idx(1'b1, s, c));
    chk("R6 index base", last_b, exp_idx(1'b0, s, c));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [5:0] s;
    logic [7:0] c, a, b;
    void'($urandom(32'd1234));
    offers = 0;
    episode(6'h3f, 2);
    episode(6'h00, 5);
    for (int e = 0; e < 4; e++) begin
      s = 6'($urandom());
      episode(s, 1 + int'($urandom() % 6));
      for (int k = 0; k < 8; k++) begin
        c = 8'($urandom());
        set_ctl(s, c);
      end
      // R10: only ignored bits move
      c = 8'h58;
      set_ctl(s, c);
      offers = 0;
      ctl = c ^ 8'h83;
      repeat (4) @(negedge clk);
      chk("R10 ignored bits no offer", offers, 0);
      ctl = 8'h00;
      repeat (4) @(negedge clk);
      offers = 0;
      ctl = 8'h04;
      repeat (4) @(negedge clk);
      chk("R10 bit2 ignored in hw mode", offers, 0);
    end
    // R9 back-pressure and R8 single offer
    a = 8'h28; b = 8'h7c;
    rdy = 1'b0;
    ctl = a;
    repeat (2) @(negedge clk);
    chk("R9 offer pending", {vld, idx}, {1'b1, exp_idx(1'b1, s, a)});
    ctl = b;
    repeat (3) @(negedge clk);
    chk("R9 offer held", {vld, idx}, {1'b1, exp_idx(1'b1, s, a)});
    rdy = 1'b1;
    @(negedge clk);
    chk("R9 accepted first", last_a, exp_idx(1'b1, s, a));
    repeat (3) @(negedge clk);
    chk("R8 later change offered", last_a, exp_idx(1'b1, s, b));
    offers = 0;
    repeat (5) @(negedge clk);
    chk("R8 no repeat offer", offers, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule